// File: doc/BRIEF.md
# Predicated Integer Execute Unit

This block is the integer execute stage of a 32-bit RISC core. Each issued operation brings a 5-bit opcode, a 3-bit predicate, the destination register index, two operands (operand B already holds register plus immediate) and the current four condition flags. The unit computes the result and the new flags, and it decides two things: whether the destination register is written back, and whether the flag register is updated. Results and enables are registered, so they appear on the clock edge that samples the issue.

Every operation is predicated: a false predicate cancels both the write-back and the flag update. Flags are also withheld from moves and immediate loads, from bit reversal and from the low-half load. They are withheld as well when the destination is the flag register or the program counter, and from anything but compare and test whenever a predicate is present. Division, floating point and memory opcodes belong to other units; they and the unassigned opcodes raise an illegal-operation output instead.

Top module: `alu_exec`

## Requirements
- R1: The flag word is {V, N, C, Z} with Z at bit 0, C at bit 1, N at bit 2 and V at bit 3; on every flag update Z is set exactly when the 32-bit result is zero and N equals result bit 31. Opcodes that are not ADD, SUB, CMP or a shift give C = 0 and V = 0.
- R2: ADD (opcode 2) returns A+B with C the carry out of bit 31; SUB (opcode 0) returns A-B with C set when A < B unsigned. For both, V is two's-complement overflow.
- R3: CMP (opcode 16) computes SUB flags and TST (opcode 17) computes AND flags; both may update flags but never assert write-back.
- R4: AND (1), OR (3) and XOR (4) return the bitwise function of A and B.
- R5: LSR (5), LSL (6) and ASR (7) shift A by the full 32-bit value of B. An amount of 32 or more gives 0 for LSR and LSL and gives the sign of A copied to every bit for ASR. C is the last bit shifted out (A bit 31 for any ASR amount of 32 or more, 0 for LSR and LSL amounts above 32) and is 0 for an amount of 0.
- R6: BREV (8) returns B bit-reversed, LDILO (9) returns {A[31:16], B[15:0]}, MOV (13) and LDI (24, 25) return B; none of these update flags.
- R7: MPY (12) returns the low 32 bits of A*B; MPYUHI (10) the high 32 bits of the unsigned 64-bit product; MPYSHI (11) the high 32 bits of the signed product.
- R8: Predicate codes: 0 always, 1 Z set, 2 N set, 3 C set, 4 V set, 5 Z clear, 6 N clear, 7 C clear, tested on the incoming flags. A false predicate clears both write-back and flag-update enables.
- R9: With a non-zero predicate that holds, only CMP and TST update flags.
- R10: An operation other than CMP or TST whose destination index is 14 or 15 does not update flags.
- R11: Opcodes 14, 15, 18 to 23 and 26 to 31 assert the illegal output and clear both enables, whatever the predicate.
- R12: Outputs are registered: the response to an issue appears after the next rising clock edge; a cycle without issue gives both enables and the illegal output low; in reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Opcode |
| cond_i | input | 3 | Predicate code |
| dst_i | input | 4 | Destination register index |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (register plus immediate) |
| flags_i | input | 4 | Current flags {V,N,C,Z} |
| result_o | output | 32 | Computed result |
| wb_en_o | output | 1 | Write the result to the destination |
| flag_en_o | output | 1 | Write flags_o to the flag register |
| flags_o | output | 4 | New flags {V,N,C,Z} |
| illegal_o | output | 1 | Opcode not handled by this unit |

## Verification
Every one of the 32 opcodes is crossed with all eight predicates, four flag patterns (none, all, and the two alternating ones) and destinations 0, 14 and 15, so predicate truth, the predicate-versus-compare rule and the destination rule are each separated from the arithmetic. Twelve operand pairs are chosen to tell apart carry from overflow, signed from unsigned multiply and zero from negative results. A separate sweep of shift amounts 0 to 40 on four patterns isolates the boundary at 32 and the carry on each side of it.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int FLAG_Z = 0;
  localparam int FLAG_C = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int NFLAGS = 4;
  localparam int OPW    = 5;
  localparam int CONDW  = 3;

  localparam logic [OPW-1:0] OP_SUB    = 5'd0;
  localparam logic [OPW-1:0] OP_AND    = 5'd1;
  localparam logic [OPW-1:0] OP_ADD    = 5'd2;
  localparam logic [OPW-1:0] OP_OR     = 5'd3;
  localparam logic [OPW-1:0] OP_XOR    = 5'd4;
  localparam logic [OPW-1:0] OP_LSR    = 5'd5;
  localparam logic [OPW-1:0] OP_LSL    = 5'd6;
  localparam logic [OPW-1:0] OP_ASR    = 5'd7;
  localparam logic [OPW-1:0] OP_BREV   = 5'd8;
  localparam logic [OPW-1:0] OP_LDLO   = 5'd9;
  localparam logic [OPW-1:0] OP_MULUH  = 5'd10;
  localparam logic [OPW-1:0] OP_MULSH  = 5'd11;
  localparam logic [OPW-1:0] OP_MUL    = 5'd12;
  localparam logic [OPW-1:0] OP_MOV    = 5'd13;
  localparam logic [OPW-1:0] OP_CMP    = 5'd16;
  localparam logic [OPW-1:0] OP_TST    = 5'd17;
  localparam logic [OPW-1:0] OP_LDI0   = 5'd24;
  localparam logic [OPW-1:0] OP_LDI1   = 5'd25;

  typedef enum logic [1:0] {
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_ARITH = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic legal;
    logic compare;
    logic quiet;
  } op_class_t;

  function automatic op_class_t classify(input logic [OPW-1:0] op);
    op_class_t c;
    c.legal   = (op <= OP_MOV) || (op == OP_CMP) || (op == OP_TST) ||
                (op == OP_LDI0) || (op == OP_LDI1);
    c.compare = (op == OP_CMP) || (op == OP_TST);
    c.quiet   = (op == OP_BREV) || (op == OP_LDLO) || (op == OP_MOV) ||
                (op == OP_LDI0) || (op == OP_LDI1);
    return c;
  endfunction

endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_exec_pkg::*;
(
  input  logic [CONDW-1:0]  cond_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic              pass_o
);
  always_comb begin
    unique case (cond_i)
      3'd0: pass_o = 1'b1;
      3'd1: pass_o = flags_i[FLAG_Z];
      3'd2: pass_o = flags_i[FLAG_N];
      3'd3: pass_o = flags_i[FLAG_C];
      3'd4: pass_o = flags_i[FLAG_V];
      3'd5: pass_o = !flags_i[FLAG_Z];
      3'd6: pass_o = !flags_i[FLAG_N];
      default: pass_o = !flags_i[FLAG_C];
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] amt_i,
  input  logic [1:0]      kind_i,
  output logic [XLEN-1:0] res_o,
  output logic            carry_o
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  logic [SHW-1:0] left_idx;
  logic           big;
  logic           exact;
  logic           sign;

  assign sh       = amt_i[SHW-1:0];
  assign left_idx = SHW'(0) - sh;
  assign big      = |amt_i[XLEN-1:SHW];
  assign exact    = (amt_i == XLEN'(XLEN));
  assign sign     = a_i[XLEN-1];

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    unique case (kind_i)
      SH_LEFT: begin
        if (big) begin
          res_o   = '0;
          carry_o = exact & a_i[0];
        end else begin
          res_o   = a_i << sh;
          carry_o = (sh != '0) & a_i[left_idx];
        end
      end
      SH_ARITH: begin
        if (big) begin
          res_o   = {XLEN{sign}};
          carry_o = sign;
        end else begin
          res_o   = $unsigned($signed(a_i) >>> sh);
          carry_o = (sh != '0) & a_i[sh - 1'b1];
        end
      end
      default: begin
        if (big) begin
          res_o   = '0;
          carry_o = exact & sign;
        end else begin
          res_o   = a_i >> sh;
          carry_o = (sh != '0) & a_i[sh - 1'b1];
        end
      end
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            carry_o,
  output logic            ovf_o
);
  localparam int HALF = XLEN / 2;
  localparam int MSB  = XLEN - 1;

  logic [XLEN:0]     sum;
  logic [XLEN-1:0]   diff;
  logic              borrow;
  logic [2*XLEN-1:0] uprod;
  logic [XLEN-1:0]   shi;
  logic [XLEN-1:0]   rev;
  logic [XLEN-1:0]   sh_res;
  logic              sh_c;

  assign sum    = {1'b0, a_i} + {1'b0, b_i};
  assign diff   = a_i - b_i;
  assign borrow = a_i < b_i;
  assign uprod  = {{XLEN{1'b0}}, a_i} * {{XLEN{1'b0}}, b_i};
  // signed high half derived from the unsigned product
  assign shi    = uprod[2*XLEN-1:XLEN] - (a_i[MSB] ? b_i : '0) - (b_i[MSB] ? a_i : '0);

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev[i] = b_i[MSB-i];
  end

  alu_shifter #(.XLEN(XLEN)) u_shift (
    .a_i    (a_i),
    .amt_i  (b_i),
    .kind_i (op_i[1:0]),
    .res_o  (sh_res),
    .carry_o(sh_c)
  );

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin
        res_o   = diff;
        carry_o = borrow;
        ovf_o   = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
      end
      OP_ADD: begin
        res_o   = sum[XLEN-1:0];
        carry_o = sum[XLEN];
        ovf_o   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      OP_LSR, OP_LSL, OP_ASR: begin
        res_o   = sh_res;
        carry_o = sh_c;
      end
      OP_BREV:  res_o = rev;
      OP_LDLO:  res_o = {a_i[XLEN-1:HALF], b_i[HALF-1:0]};
      OP_MULUH: res_o = uprod[2*XLEN-1:XLEN];
      OP_MULSH: res_o = shi;
      OP_MUL:   res_o = uprod[XLEN-1:0];
      OP_MOV, OP_LDI0, OP_LDI1: res_o = b_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REGW   = 4,
  parameter int CC_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OPW-1:0]    op_i,
  input  logic [CONDW-1:0]  cond_i,
  input  logic [REGW-1:0]   dst_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wb_en_o,
  output logic              flag_en_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              illegal_o
);
  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  op_class_t         cls;
  logic              pass;
  logic [XLEN-1:0]   dp_res;
  logic              dp_c;
  logic              dp_v;
  logic              dst_special;
  logic              go;

  logic [XLEN-1:0]   result_d;
  logic [NFLAGS-1:0] flags_d;
  logic              wb_d;
  logic              fe_d;
  logic              ill_d;

  assign cls         = classify(op_i);
  assign dst_special = (dst_i == REGW'(CC_IDX)) || (dst_i == REGW'(PC_IDX));

  alu_cond_eval u_cond (
    .cond_i (cond_i),
    .flags_i(flags_i),
    .pass_o (pass)
  );

  alu_datapath #(.XLEN(XLEN)) u_dp (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (dp_res),
    .carry_o(dp_c),
    .ovf_o  (dp_v)
  );

  always_comb begin
    go       = issue_i & cls.legal & pass;
    wb_d     = go & !cls.compare;
    fe_d     = go & !cls.quiet
             & ((cond_i == '0) | cls.compare)
             & (cls.compare | !dst_special);
    ill_d    = issue_i & !cls.legal;
    result_d = cls.legal ? dp_res : '0;
    flags_d  = '0;
    flags_d[FLAG_Z] = (dp_res == '0);
    flags_d[FLAG_C] = dp_c;
    flags_d[FLAG_N] = dp_res[XLEN-1];
    flags_d[FLAG_V] = dp_v;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_en_o   <= 1'b0;
      flag_en_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wb_en_o   <= wb_d;
      flag_en_o <= fe_d;
      illegal_o <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (issue_i) begin
      result_o <= result_d;
      flags_o  <= flags_d;
    end
  end
endmodule

// File: rtl/alu_exec_checker.sv
module alu_exec_checker
  import alu_exec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REGW   = 4,
  parameter int CC_IDX = 14,
  parameter int PC_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_i,
  input logic [OPW-1:0]    op_i,
  input logic [CONDW-1:0]  cond_i,
  input logic [REGW-1:0]   dst_i,
  input logic [XLEN-1:0]   a_i,
  input logic [XLEN-1:0]   b_i,
  input logic [NFLAGS-1:0] flags_i,
  input logic [XLEN-1:0]   result_o,
  input logic              wb_en_o,
  input logic              flag_en_o,
  input logic [NFLAGS-1:0] flags_o,
  input logic              illegal_o
);
  localparam int HALF = XLEN / 2;

  logic cmp_op, bad_op, false_cond, to_special;
  assign cmp_op     = (op_i == 5'd16) || (op_i == 5'd17);
  assign bad_op     = (op_i == 5'd14) || (op_i == 5'd15) ||
                      ((op_i >= 5'd18) && (op_i <= 5'd23)) || (op_i >= 5'd26);
  assign false_cond = ((cond_i == 3'd1) && !flags_i[FLAG_Z]) ||
                      ((cond_i == 3'd5) &&  flags_i[FLAG_Z]) ||
                      ((cond_i == 3'd3) && !flags_i[FLAG_C]) ||
                      ((cond_i == 3'd7) &&  flags_i[FLAG_C]);
  assign to_special = (dst_i == REGW'(CC_IDX)) || (dst_i == REGW'(PC_IDX));

  a_r3_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cmp_op) |=> !wb_en_o);

  a_r8_false_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && false_cond) |=> (!wb_en_o && !flag_en_o));

  a_r9_cond_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (cond_i != 3'd0) && !cmp_op) |=> !flag_en_o);

  a_r10_dst_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && to_special && !cmp_op) |=> !flag_en_o);

  a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && bad_op) |=> (illegal_o && !wb_en_o && !flag_en_o));

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wb_en_o && !flag_en_o && !illegal_o));

  a_r1_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en_o |-> (flags_o[FLAG_Z] == (result_o == '0)) && (flags_o[FLAG_N] == result_o[XLEN-1]));

  a_r6_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == 5'd9) && (cond_i == 3'd0)) |=>
      (result_o == {$past(a_i[XLEN-1:HALF]), $past(b_i[HALF-1:0])}) && !flag_en_o);

  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_o, wb_en_o}) && $onehot0({illegal_o, flag_en_o}));
endmodule

bind alu_exec alu_exec_checker #(
  .XLEN(XLEN), .REGW(REGW), .CC_IDX(CC_IDX), .PC_IDX(PC_IDX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .issue_i  (issue_i),
  .op_i     (op_i),
  .cond_i   (cond_i),
  .dst_i    (dst_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .wb_en_o  (wb_en_o),
  .flag_en_o(flag_en_o),
  .flags_o  (flags_o),
  .illegal_o(illegal_o)
);

// File: tb/alu_exec_test.sv
`timescale 1ns/1ps
module alu_exec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [4:0]  op_i;
  logic [2:0]  cond_i;
  logic [3:0]  dst_i;
  logic [31:0] a_i, b_i;
  logic [3:0]  flags_i;
  logic [31:0] result_o;
  logic        wb_en_o, flag_en_o, illegal_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  alu_exec uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .cond_i(cond_i),
    .dst_i(dst_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
    .result_o(result_o), .wb_en_o(wb_en_o), .flag_en_o(flag_en_o),
    .flags_o(flags_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] pick_a(int i);
    case (i)
      0: return 32'h0;          1: return 32'h1;
      2: return 32'hFFFFFFFF;   3: return 32'h7FFFFFFF;
      4: return 32'h80000000;   5: return 32'h80000000;
      6: return 32'h5;          7: return 32'h12345678;
      8: return 32'hDEADBEEF;   9: return 32'h0000FFFF;
      10: return 32'h3;         default: return 32'h80000001;
    endcase
  endfunction

  function automatic logic [31:0] pick_b(int i);
    case (i)
      0: return 32'h0;          1: return 32'h1;
      2: return 32'h1;          3: return 32'h1;
      4: return 32'h1;          5: return 32'h80000000;
      6: return 32'h7;          7: return 32'h9ABCDEF0;
      8: return 32'h4;          9: return 32'hFFFF0000;
      10: return 32'h21;        default: return 32'h1F;
    endcase
  endfunction

  function automatic logic [3:0] pick_f(int i);
    case (i)
      0: return 4'h0; 1: return 4'hF; 2: return 4'h5; default: return 4'hA;
    endcase
  endfunction

  function automatic logic is_legal(logic [4:0] op);
    return (op <= 5'd13) || op == 5'd16 || op == 5'd17 || op == 5'd24 || op == 5'd25;
  endfunction

  function automatic logic is_cmp(logic [4:0] op);
    return op == 5'd16 || op == 5'd17;
  endfunction

  function automatic logic is_quiet(logic [4:0] op);
    return op == 5'd8 || op == 5'd9 || op == 5'd13 || op == 5'd24 || op == 5'd25;
  endfunction

  // R8: predicate table on {V,N,C,Z}
  function automatic logic cond_true(logic [2:0] c, logic [3:0] f);
    case (c)
      3'd0: return 1'b1;  3'd1: return f[0];  3'd2: return f[2];  3'd3: return f[1];
      3'd4: return f[3];  3'd5: return !f[0]; 3'd6: return !f[2]; default: return !f[1];
    endcase
  endfunction

  // expected {C,V,result} from the arithmetic definitions
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic c, output logic v);
    logic [63:0] up, sp;
    r = 0; c = 0; v = 0;
    up = {32'b0, a} * {32'b0, b};
    sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    case (op)
      5'd0, 5'd16: begin r = a - b; c = a < b; v = (a[31] != b[31]) && (r[31] != a[31]); end
      5'd2: begin {c, r} = {1'b0, a} + {1'b0, b}; v = (a[31] == b[31]) && (r[31] != a[31]); end
      5'd1, 5'd17: r = a & b;
      5'd3: r = a | b;
      5'd4: r = a ^ b;
      5'd5: begin
        r = (b >= 32) ? 0 : a >> b;
        c = (b == 0 || b > 32) ? 1'b0 : a[b - 1];
      end
      5'd6: begin
        r = (b >= 32) ? 0 : a << b;
        c = (b == 0 || b > 32) ? 1'b0 : a[32 - b];
      end
      5'd7: begin
        r = (b >= 32) ? {32{a[31]}} : $unsigned($signed(a) >>> b[4:0]);
        c = (b == 0) ? 1'b0 : (b >= 32) ? a[31] : a[b - 1];
      end
      5'd8: for (int k = 0; k < 32; k++) r[k] = b[31 - k];
      5'd9: r = {a[31:16], b[15:0]};
      5'd10: r = up[63:32];
      5'd11: r = sp[63:32];
      5'd12: r = up[31:0];
      default: r = b;
    endcase
  endtask

  function automatic string tag_of(logic [4:0] op, logic pass, logic [2:0] c, logic [3:0] d);
    if (!is_legal(op)) return "R11";
    if (!pass) return "R8";
    if (c != 0 && !is_cmp(op)) return "R9";
    if ((d == 14 || d == 15) && !is_cmp(op) && !is_quiet(op)) return "R10";
    case (op)
      5'd16, 5'd17: return "R3 R1";
      5'd0, 5'd2: return "R2 R1";
      5'd1, 5'd3, 5'd4: return "R4 R1";
      5'd5, 5'd6, 5'd7: return "R5 R1";
      5'd10, 5'd11, 5'd12: return "R7 R1";
      default: return "R6";
    endcase
  endfunction

  task automatic run_vec(input logic [4:0] op, input logic [2:0] c, input logic [3:0] d,
                         input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    logic [31:0] er; logic ec, ev, ok, pass, ewb, efe, eill;
    logic [3:0] ef;
    model(op, a, b, er, ec, ev);
    pass = cond_true(c, f);
    eill = !is_legal(op);
    ewb  = !eill && pass && !is_cmp(op);
    efe  = !eill && pass && !is_quiet(op) && (c == 0 || is_cmp(op)) &&
           (is_cmp(op) || !(d == 14 || d == 15));
    ef   = {ev, er[31], ec, er == 0};
    @(negedge clk);
    issue_i = 1; op_i = op; cond_i = c; dst_i = d; a_i = a; b_i = b; flags_i = f;
    @(negedge clk);
    issue_i = 0;
    ok = (wb_en_o == ewb) && (flag_en_o == efe) && (illegal_o == eill) &&
         (!(ewb || efe) || result_o == er) && (!efe || flags_o == ef);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d cond=%0d dst=%0d a=%h b=%h fl=%h: got res=%h wb=%b fe=%b fl=%h ill=%b exp res=%h wb=%b fe=%b fl=%h ill=%b",
               tag_of(op, pass, c, d), op, c, d, a, b, f, result_o, wb_en_o, flag_en_o,
               flags_o, illegal_o, er, ewb, efe, ef, eill);
    end
  endtask

  task automatic expect_bits(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    #950us;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; issue_i = 0; op_i = 0; cond_i = 0; dst_i = 0; a_i = 0; b_i = 0; flags_i = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    expect_bits("R12 reset", {result_o, wb_en_o, flag_en_o, illegal_o, flags_o, 1'b0},
                40'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: directed flag encoding, 0xFFFFFFFF + 1 gives Z and C only
    run_vec(5'd2, 3'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 4'h0);
    expect_bits("R1 flag bits", {36'h0, flags_o}, {36'h0, 4'b0011});
    // R2: overflow without carry, 0x7FFFFFFF + 1 gives V and N
    run_vec(5'd2, 3'd0, 4'd0, 32'h7FFFFFFF, 32'h1, 4'h0);
    expect_bits("R2 ovf", {36'h0, flags_o}, {36'h0, 4'b1100});

    // R12: idle cycle gives no enables
    @(negedge clk);
    expect_bits("R12 idle", {37'h0, wb_en_o, flag_en_o, illegal_o}, 40'h0);

    // main sweep: all opcodes, predicates, flag patterns, destinations, operands
    for (int op = 0; op < 32; op++)
      for (int c = 0; c < 8; c++)
        for (int fi = 0; fi < 4; fi++)
          for (int di = 0; di < 3; di++)
            for (int oi = 0; oi < 12; oi++)
              run_vec(5'(op), 3'(c), (di == 0) ? 4'd0 : (di == 1) ? 4'd14 : 4'd15,
                      pick_a(oi), pick_b(oi), pick_f(fi));

    // R5: shift amount sweep across the 32 boundary
    for (int op = 5; op < 8; op++)
      for (int n = 0; n <= 40; n++)
        for (int ai = 0; ai < 4; ai++)
          run_vec(5'(op), 3'd0, 4'd1,
                  (ai == 0) ? 32'h80000001 : (ai == 1) ? 32'h7FFFFFFE :
                  (ai == 2) ? 32'hA5A5A5A5 : 32'hFFFFFFFF, 32'(n), 4'h0);
    run_vec(5'd7, 3'd0, 4'd1, 32'h80000000, 32'hFFFFFFFF, 4'h0);
    run_vec(5'd5, 3'd0, 4'd1, 32'hFFFFFFFF, 32'h100, 4'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule